// File: doc/BRIEF.md
# Receive Lane Bring-Up Sequencer

This block brings one serial receive lane out of power-down without software involvement. A one-cycle start pulse begins the run. The block first requests transmit-lane enable and waits for the transmit side to answer. It then works a 32-bit receive control word through a fixed chain of bit edits: it takes manual control, powers the receiver up, starts calibration and waits for the PHY to report that calibration has finished.

With calibration complete, the block enables receive data and enters a clock-recovery loop. Each attempt pulses the clock-recovery reset, raises PHY-ready and samples a block-lock indication. Missing lock costs one millisecond of waiting and another attempt. Lock, or an exhausted budget, ends the run with a sticky done or fail flag. An attempt counter stays visible so the retry limit can be observed.

The millisecond is a parameter counted in clock cycles. Simulation can therefore shrink it while keeping the real poll and retry budgets.

Top module: `rx_lane_sequencer`

## Requirements
- R1: After reset `ctrl_o` is 0x000000F0 (bit 4 power-down, bit 5 auxiliary power-down and sleep field bits 7:6 all set, every other bit zero). `done_o`, `fail_o`, `tx_en_o` and `attempts_o` are all zero.
- R2: A start pulse in idle reloads `ctrl_o` with 0x000000F0 and raises `tx_en_o` on the next edge. `ctrl_o` stays unchanged while `tx_en_o` is high. `tx_err_i` ends the run with `fail_o`, `attempts_o` 0 and `ctrl_o` 0x000000F0.
- R3: After `tx_ack_i`, `ctrl_o` changes once per cycle through 0x800000F0 (bit 31 override set), 0x800000E0 (bit 4 cleared), 0x800000C0 (bit 5 cleared), 0x80000000 (bits 7:6 cleared) and 0x80000100 (bit 8 calibration enable set), in that order.
- R4: Once bit 8 is visible, `cal_done_i` is sampled one cycle later and then every `CYC_PER_MS` cycles, for at most `CAL_POLL_MAX` samples. If none of these samples sees it high, the run fails with `ctrl_o` 0x80000100 and `attempts_o` 0.
- R5: A high calibration sample clears bit 8 and then sets bit 0 (data enable). Bit 0 stays set until the next accepted start, and is never set together with bit 8.
- R6: Each lock attempt adds one to `attempts_o`, holds bit 9 (clock-recovery reset) high for exactly `CDR_HOLD` cycles and clears it. It then sets bit 10 (PHY-ready) and samples `lock_i` once.
- R7: The first attempt that samples `lock_i` high ends the run with `done_o`, `attempts_o` equal to that attempt's number, and `ctrl_o` 0x80000401.
- R8: When `LOCK_MAX` attempts all miss lock, the run ends with `fail_o`, `attempts_o` equal to `LOCK_MAX` and `ctrl_o` 0x80000401.
- R9: `done_o` and `fail_o` are never high together and hold until the next start. A start pulse while a run is busy has no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a bring-up run |
| tx_ack_i | input | 1 | Transmit lane reports successful enable |
| tx_err_i | input | 1 | Transmit lane reports enable failure |
| cal_done_i | input | 1 | PHY has finished calibration (clears bit 8) |
| lock_i | input | 1 | Block lock seen by the PCS |
| tx_en_o | output | 1 | Transmit lane enable request |
| ctrl_o | output | 32 | Receive lane control word |
| done_o | output | 1 | Run ended with lock |
| fail_o | output | 1 | Run ended without lock or on a failed step |
| attempts_o | output | $clog2(LOCK_MAX+1) | Lock attempts made in the current run |

## Verification
Runs are built from four inputs: the transmit answer (acknowledge or error, after a random delay), the calibration finish time in cycles after bit 8 rises, the attempt at which lock first appears, and an optional stray start pulse mid-run. Finish times on both sides of the last calibration sample separate an off-by-one in poll spacing or poll count from correct behaviour. Lock on exactly the last allowed attempt, and on the one after it, does the same for the retry budget. Recorded control-word transitions and reset pulse widths tell a wrong step order or hold length apart from a right outcome reached by a wrong path.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;

    localparam int unsigned BIT_DATA_EN  = 0;
    localparam int unsigned BIT_PWR_DN   = 4;
    localparam int unsigned BIT_AUX_DN   = 5;
    localparam int unsigned BIT_SLEEP_LO = 6;
    localparam int unsigned BIT_SLEEP_HI = 7;
    localparam int unsigned BIT_CAL_EN   = 8;
    localparam int unsigned BIT_CDR_RST  = 9;
    localparam int unsigned BIT_PHY_RDY  = 10;
    localparam int unsigned BIT_OVERRIDE = 31;

    localparam logic [31:0] CTRL_RESET = 32'h0000_00F0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TX_WAIT,
        ST_OVERRIDE,
        ST_PWR_UP,
        ST_AUX_UP,
        ST_WAKE,
        ST_CAL_START,
        ST_CAL_POLL,
        ST_CAL_WAIT,
        ST_DATA_ON,
        ST_ATT_START,
        ST_CDR_HOLD,
        ST_READY,
        ST_LOCK_CHECK,
        ST_LOCK_WAIT
    } seq_state_e;

    typedef struct packed {
        seq_state_e  state;
        logic [31:0] ctrl;
        logic        done;
        logic        fail;
    } seq_reg_t;

endpackage

// File: rtl/rxseq_interval.sv
module rxseq_interval #(
    parameter int unsigned TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = run_i && (cnt_q == CW'(TICKS - 1));
        if (!run_i || expire_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/rxseq_budget.sv
module rxseq_budget #(
    parameter int unsigned LIMIT = 300,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [CW-1:0] count_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != CW'(LIMIT))) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/rx_lane_sequencer.sv
module rx_lane_sequencer
    import rxseq_pkg::*;
#(
    parameter int unsigned CYC_PER_MS   = 50000,
    parameter int unsigned CAL_POLL_MAX = 1000,
    parameter int unsigned LOCK_MAX     = 300,
    parameter int unsigned CDR_HOLD     = 4,
    localparam int unsigned ATT_W       = $clog2(LOCK_MAX + 1),
    localparam int unsigned POLL_W      = $clog2(CAL_POLL_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tx_ack_i,
    input  logic             tx_err_i,
    input  logic             cal_done_i,
    input  logic             lock_i,
    output logic             tx_en_o,
    output logic [31:0]      ctrl_o,
    output logic             done_o,
    output logic             fail_o,
    output logic [ATT_W-1:0] attempts_o
);
    // Calibration polls are one cycle of sampling plus (CYC_PER_MS-1) of waiting.
    localparam int unsigned CAL_GAP  = (CYC_PER_MS > 1) ? CYC_PER_MS - 1 : 1;
    localparam int unsigned HOLD_LEN = (CDR_HOLD > 0) ? CDR_HOLD : 1;

    seq_reg_t r_q, r_d;

    logic              cal_tick, lock_tick, hold_tick;
    logic              poll_clr, poll_inc, att_clr, att_inc;
    logic [POLL_W-1:0] poll_cnt;
    logic [ATT_W-1:0]  att_cnt;

    rxseq_interval #(.TICKS(CAL_GAP)) u_cal_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (r_q.state == ST_CAL_WAIT),
        .expire_o(cal_tick)
    );

    rxseq_interval #(.TICKS(CYC_PER_MS)) u_lock_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (r_q.state == ST_LOCK_WAIT),
        .expire_o(lock_tick)
    );

    rxseq_interval #(.TICKS(HOLD_LEN)) u_cdr_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (r_q.state == ST_CDR_HOLD),
        .expire_o(hold_tick)
    );

    rxseq_budget #(.LIMIT(CAL_POLL_MAX)) u_poll_budget (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (poll_clr),
        .inc_i  (poll_inc),
        .count_o(poll_cnt)
    );

    rxseq_budget #(.LIMIT(LOCK_MAX)) u_att_budget (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (att_clr),
        .inc_i  (att_inc),
        .count_o(att_cnt)
    );

    always_comb begin
        r_d      = r_q;
        poll_clr = 1'b0;
        poll_inc = 1'b0;
        att_clr  = 1'b0;
        att_inc  = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.ctrl  = CTRL_RESET;
                    r_d.done  = 1'b0;
                    r_d.fail  = 1'b0;
                    poll_clr  = 1'b1;
                    att_clr   = 1'b1;
                    r_d.state = ST_TX_WAIT;
                end
            end
            ST_TX_WAIT: begin
                if (tx_err_i) begin
                    r_d.fail  = 1'b1;
                    r_d.state = ST_IDLE;
                end else if (tx_ack_i) begin
                    r_d.state = ST_OVERRIDE;
                end
            end
            ST_OVERRIDE: begin
                r_d.ctrl[BIT_OVERRIDE] = 1'b1;
                r_d.state              = ST_PWR_UP;
            end
            ST_PWR_UP: begin
                r_d.ctrl[BIT_PWR_DN] = 1'b0;
                r_d.state            = ST_AUX_UP;
            end
            ST_AUX_UP: begin
                r_d.ctrl[BIT_AUX_DN] = 1'b0;
                r_d.state            = ST_WAKE;
            end
            ST_WAKE: begin
                r_d.ctrl[BIT_SLEEP_HI:BIT_SLEEP_LO] = 2'b00;
                r_d.state                           = ST_CAL_START;
            end
            ST_CAL_START: begin
                r_d.ctrl[BIT_CAL_EN] = 1'b1;
                r_d.state            = ST_CAL_POLL;
            end
            ST_CAL_POLL: begin
                if (cal_done_i) begin
                    r_d.ctrl[BIT_CAL_EN] = 1'b0;
                    r_d.state            = ST_DATA_ON;
                end else begin
                    poll_inc  = 1'b1;
                    r_d.state = ST_CAL_WAIT;
                end
            end
            ST_CAL_WAIT: begin
                if (poll_cnt == POLL_W'(CAL_POLL_MAX)) begin
                    r_d.fail  = 1'b1;
                    r_d.state = ST_IDLE;
                end else if (cal_tick) begin
                    r_d.state = ST_CAL_POLL;
                end
            end
            ST_DATA_ON: begin
                r_d.ctrl[BIT_DATA_EN] = 1'b1;
                r_d.state             = ST_ATT_START;
            end
            ST_ATT_START: begin
                r_d.ctrl[BIT_CDR_RST] = 1'b1;
                att_inc               = 1'b1;
                r_d.state             = ST_CDR_HOLD;
            end
            ST_CDR_HOLD: begin
                if (hold_tick) begin
                    r_d.ctrl[BIT_CDR_RST] = 1'b0;
                    r_d.state             = ST_READY;
                end
            end
            ST_READY: begin
                r_d.ctrl[BIT_PHY_RDY] = 1'b1;
                r_d.state             = ST_LOCK_CHECK;
            end
            ST_LOCK_CHECK: begin
                if (lock_i) begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end else if (att_cnt == ATT_W'(LOCK_MAX)) begin
                    r_d.fail  = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.state = ST_LOCK_WAIT;
                end
            end
            ST_LOCK_WAIT: begin
                if (lock_tick) begin
                    r_d.state = ST_ATT_START;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.ctrl  <= CTRL_RESET;
            r_q.done  <= 1'b0;
            r_q.fail  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_en_o    = (r_q.state == ST_TX_WAIT);
    assign ctrl_o     = r_q.ctrl;
    assign done_o     = r_q.done;
    assign fail_o     = r_q.fail;
    assign attempts_o = att_cnt;
endmodule

// File: rtl/rx_lane_sequencer_chk.sv
module rx_lane_sequencer_chk #(
    parameter int unsigned LOCK_MAX = 300,
    localparam int unsigned ATT_W   = $clog2(LOCK_MAX + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             tx_en_o,
    input logic [31:0]      ctrl_o,
    input logic             done_o,
    input logic             fail_o,
    input logic [ATT_W-1:0] attempts_o
);
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

    p_done_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    p_fail_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> fail_o);

    p_tx_word_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_o |-> (ctrl_o == 32'h0000_00F0));

    p_power_before_override_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o[31] |-> (ctrl_o[7:4] == 4'hF));

    p_data_excludes_cal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[0] |-> !ctrl_o[8]);

    p_data_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[0] && !start_i) |=> ctrl_o[0]);

    p_ready_after_cdr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_o[9]) |=> ctrl_o[10]);

    p_attempt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (attempts_o != $past(attempts_o)) |->
            ((attempts_o == $past(attempts_o) + 1'b1) || (attempts_o == '0)));

    p_attempt_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        attempts_o <= ATT_W'(LOCK_MAX));
endmodule

bind rx_lane_sequencer rx_lane_sequencer_chk #(.LOCK_MAX(LOCK_MAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .tx_en_o   (tx_en_o),
    .ctrl_o    (ctrl_o),
    .done_o    (done_o),
    .fail_o    (fail_o),
    .attempts_o(attempts_o)
);

// File: tb/rx_lane_sequencer_tb.sv
module rx_lane_sequencer_tb;
    localparam int M     = 5;
    localparam int PMAX  = 1000;
    localparam int LMAX  = 300;
    localparam int HOLD  = 3;
    localparam int AW    = $clog2(LMAX + 1);
    localparam int CAL_B = 1 + (PMAX - 1) * M;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          tx_ack_i = 1'b0;
    logic          tx_err_i = 1'b0;
    logic          cal_done_i = 1'b0;
    logic          lock_i = 1'b0;
    logic          tx_en_o;
    logic [31:0]   ctrl_o;
    logic          done_o;
    logic          fail_o;
    logic [AW-1:0] attempts_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int cal_t = 1;
    int lock_l = 1;
    int cal_cyc = 0;
    bit rec_on = 1'b0;
    logic [31:0] prev_ctrl;
    logic [31:0] seq [8];
    int seq_n = 0;
    int run_len = 0;
    int runs = 0;
    bit run_bad = 1'b0;

    always #10 clk = ~clk;

    rx_lane_sequencer #(
        .CYC_PER_MS  (M),
        .CAL_POLL_MAX(PMAX),
        .LOCK_MAX    (LMAX),
        .CDR_HOLD    (HOLD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .tx_ack_i(tx_ack_i), .tx_err_i(tx_err_i),
        .cal_done_i(cal_done_i), .lock_i(lock_i),
        .tx_en_o(tx_en_o), .ctrl_o(ctrl_o), .done_o(done_o),
        .fail_o(fail_o), .attempts_o(attempts_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic bit cal_ok(input int t);
        return t <= CAL_B;
    endfunction

    // PHY, lock detector and observation, all acting at the falling edge.
    task automatic phy_model();
        forever begin
            @(negedge clk);
            if (ctrl_o[8]) cal_cyc++;
            else cal_cyc = 0;
            cal_done_i = (cal_cyc >= cal_t);
            lock_i = (int'(attempts_o) >= lock_l);
            if (rec_on && ctrl_o != prev_ctrl) begin
                if (seq_n < 8) seq[seq_n] = ctrl_o;
                seq_n++;
                prev_ctrl = ctrl_o;
            end
            if (ctrl_o[9]) run_len++;
            else if (run_len > 0) begin
                runs++;
                if (run_len != HOLD) run_bad = 1'b1;
                run_len = 0;
            end
        end
    endtask

    task automatic run_case(input int tx_dly, input bit tx_bad, input int t_cal,
                            input int l_lock, input bit poke);
        bit e_done, e_fail;
        int e_att;
        logic [31:0] e_ctrl;
        logic [31:0] e_seq [5];
        e_seq = '{32'h800000F0, 32'h800000E0, 32'h800000C0, 32'h80000000, 32'h80000100};
        if (tx_bad) begin
            e_done = 0; e_fail = 1; e_att = 0; e_ctrl = 32'h000000F0;
        end else if (!cal_ok(t_cal)) begin
            e_done = 0; e_fail = 1; e_att = 0; e_ctrl = 32'h80000100;
        end else if (l_lock <= LMAX) begin
            e_done = 1; e_fail = 0; e_att = l_lock; e_ctrl = 32'h80000401;
        end else begin
            e_done = 0; e_fail = 1; e_att = LMAX; e_ctrl = 32'h80000401;
        end
        cal_t = t_cal; lock_l = l_lock;
        seq_n = 0; runs = 0; run_bad = 0; run_len = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(tx_en_o && ctrl_o == 32'hF0 && !done_o && !fail_o, "R2 start",
            {tx_en_o, ctrl_o}, {1'b1, 32'hF0});
        prev_ctrl = ctrl_o; rec_on = 1'b1;
        repeat (tx_dly) @(negedge clk);
        chk(tx_en_o && ctrl_o == 32'hF0, "R2 tx wait", {tx_en_o, ctrl_o}, {1'b1, 32'hF0});
        if (tx_bad) tx_err_i = 1'b1; else tx_ack_i = 1'b1;
        @(negedge clk); tx_err_i = 1'b0; tx_ack_i = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk); start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
        end
        while (!(done_o || fail_o)) @(negedge clk);
        rec_on = 1'b0;
        chk(done_o == e_done && fail_o == e_fail,
            tx_bad ? "R2 outcome" : (!cal_ok(t_cal) ? "R4 outcome" :
                (e_done ? "R7 outcome" : "R8 outcome")),
            {done_o, fail_o}, {e_done, e_fail});
        chk(int'(attempts_o) == e_att, e_done ? "R7 attempts" : "R8 attempts",
            attempts_o, e_att);
        chk(ctrl_o == e_ctrl, e_done ? "R5 final word" : "R4 final word", ctrl_o, e_ctrl);
        if (!tx_bad) begin
            for (int i = 0; i < 5; i++)
                chk(seq_n > i && seq[i] == e_seq[i], "R3 step order", seq[i], e_seq[i]);
        end
        if (!tx_bad && cal_ok(t_cal))
            chk(runs == e_att && !run_bad, "R6 cdr pulses", {run_bad, 31'(runs)}, e_att);
        repeat (4) @(negedge clk);
        chk(done_o == e_done && fail_o == e_fail && !(done_o && fail_o), "R9 held",
            {done_o, fail_o}, {e_done, e_fail});
    endtask

    initial begin
        void'($urandom(32'd1234));
        fork phy_model(); join_none
        repeat (3) @(negedge clk);
        chk(ctrl_o == 32'hF0 && !done_o && !fail_o && !tx_en_o && attempts_o == 0,
            "R1 reset", {done_o, fail_o, tx_en_o, ctrl_o}, 32'hF0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctrl_o == 32'hF0 && !tx_en_o && attempts_o == 0, "R1 after release",
            ctrl_o, 32'hF0);
        run_case(2, 0, 3, 1, 0);           // plain success
        run_case(1, 1, 3, 1, 0);           // R2 transmit error
        run_case(0, 0, CAL_B, 2, 0);       // R4 last poll catches it
        run_case(3, 0, CAL_B + 1, 2, 0);   // R4 one cycle too late
        run_case(1, 0, 7, LMAX, 0);        // R7 lock on last attempt
        run_case(1, 0, 7, LMAX + 1, 0);    // R8 retry budget spent
        run_case(2, 0, 12, 4, 1);          // R9 start while busy
        for (int k = 0; k < 10; k++) begin
            int d = $urandom_range(0, 6);
            bit bad = ($urandom_range(0, 7) == 0);
            int t = $urandom_range(1, 40);
            int l = ($urandom_range(0, 5) == 0) ? 100000 : $urandom_range(1, 30);
            bit pk = !bad && ($urandom_range(0, 3) == 0);
            run_case(d, bad, t, l, pk);
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule